// File: doc/BRIEF.md
# ATA Command-Window Configuration Unlock Sequencer

This block sits on the device side of an IDE channel's command-block I/O decode. In its normal (locked) state, every access on the eight-offset I/O window is forwarded unchanged to the task-file pass-through port. Read data comes back from that port in the same cycle.

A covert pattern of ordinary accesses swaps the window over to a hidden configuration bank. The pattern is two 16-bit reads at offset 1 and then an 8-bit write of 0x03 at offset 2. While the bank is visible, the task-file port sees nothing. Software can then:
- load per-drive read and write timing values;
- set a shared address-setup field;
- read back a clock-rate strap;
- commit the programmed timing sets to the drive timing outputs.

Writing 0x83 at offset 2 returns the window to task-file mode.

The I/O bus is a single-cycle strobe bus with no back-pressure. Each strobe is high for exactly one clock, and the access completes in that clock. Read data is valid combinationally while a read strobe is high. Only one strobe is expected per cycle. A cycle with several strobes high is treated as an access that fits no pattern.

Top module: `ata_win_unlock`

## Requirements
- R1: After reset the window is locked (`cfg_mode`=0), the sequence is idle, both drives' staged and applied timings are 0x00, the address-setup field and output are 0, the drive select is 0 and `timing_live` is 0.
- R2: While locked, every strobe is copied to the matching task-file strobe in the same cycle, with `tf_addr`=`io_addr` and `tf_wdata`=`io_wdata`. On a read, `io_rdata` equals `tf_rdata`.
- R3: The sequence is a 16-bit read at offset 1, another 16-bit read at offset 1, then an 8-bit write with low byte 0x03 at offset 2. It sets `cfg_mode` from the clock edge that ends the write. All three accesses are still passed through.
- R4: Any other access in the middle of the pattern sends the sequence back to its start. This covers an 8-bit read at offset 1, any access at another offset, a wrong value at offset 2, or a 16-bit write at offset 2. A later attempt must begin again with the first 16-bit read.
- R5: While unlocked, no task-file strobe is asserted for any access.
- R6: While unlocked, an 8-bit write of 0x83 at offset 2 clears `cfg_mode` from the next edge, and the window passes accesses through again.
- R7: Unlocked writes at offset 0 (read timing) and offset 1 (write timing) load the staged set of the drive chosen by misc bit 0. Reads at those offsets return the selected drive's staged value.
- R8: The misc register at offset 6 stores a full byte and reads it back. Bit 0 is the drive select, and bits 7:4 form the address-setup field shared by both drives.
- R9: The control register at offset 3 stores and reads back any byte. Only a write of 0x85 copies both staged sets and the address-setup field to `drv_rd_tim`, `drv_wr_tim` and `addr_setup`, and sets `timing_live`. Other values leave those outputs unchanged.
- R10: A read at offset 5 returns `clk25_strap` in bit 0 and zeros above it (0 means 33 MHz, 1 means 25 MHz). Writes at offset 5 are ignored.
- R11: While unlocked, reads at offsets 2, 4 and 7 return 0x00. Writes there are ignored, apart from the relock write at offset 2.
- R12: Configuration reads return the register byte in bits 7:0 with bits 15:8 at zero. A 16-bit write uses its low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 3 | Window offset 0..7 |
| io_rd8 | input | 1 | 8-bit read strobe |
| io_rd16 | input | 1 | 16-bit read strobe |
| io_wr8 | input | 1 | 8-bit write strobe |
| io_wr16 | input | 1 | 16-bit write strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data (task-file or configuration) |
| cfg_mode | output | 1 | 1 while the configuration bank owns the window |
| tf_addr | output | 3 | Forwarded offset |
| tf_rd8 | output | 1 | Forwarded 8-bit read |
| tf_rd16 | output | 1 | Forwarded 16-bit read |
| tf_wr8 | output | 1 | Forwarded 8-bit write |
| tf_wr16 | output | 1 | Forwarded 16-bit write |
| tf_wdata | output | 16 | Forwarded write data |
| tf_rdata | input | 16 | Task-file read data |
| clk25_strap | input | 1 | Bus-clock strap, 1 = 25 MHz |
| drv_rd_tim | output | 16 | Applied read timing, drive d in bits d*8+7:d*8 |
| drv_wr_tim | output | 16 | Applied write timing, same packing |
| addr_setup | output | 4 | Applied shared address-setup field |
| timing_live | output | 1 | Set once a commit has occurred |

## Verification
The checker watches every cycle for four rules:
- the locked/unlocked switch happens only after the exact unlock or relock write;
- no task-file strobe appears while unlocked;
- the strap read always reflects the pin;
- the applied timing outputs move only on a 0x85 commit.

Only the bench's scenarios can show the ordering rules of the unlock pattern. These include restarting after each kind of breaking access at either position, as well as drive-select steering, readback of each register, and the ignored offsets. Those checks depend on a history of several accesses, not a single cycle.

// File: rtl/ata_win_pkg.sv
package ata_win_pkg;
  // window offsets whose decode other logic relies on
  localparam int OFF_RTIM  = 0;
  localparam int OFF_WTIM  = 1;
  localparam int OFF_LOCK  = 2;
  localparam int OFF_CTRL  = 3;
  localparam int OFF_STRAP = 5;
  localparam int OFF_MISC  = 6;
  localparam int OFF_KEY_RD = 1;

  localparam logic [7:0] KEY_UNLOCK = 8'h03;
  localparam logic [7:0] KEY_RELOCK = 8'h83;
  localparam logic [7:0] KEY_COMMIT = 8'h85;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2
  } seq_t;
endpackage

// File: rtl/ata_win_seq.sv
module ata_win_seq
  import ata_win_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd8,
  input  logic              rd16,
  input  logic              wr8,
  input  logic              wr16,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              cfg_mode
);
  seq_t       st_q;
  logic [2:0] n_strb;
  logic       any_acc, one_acc;
  logic       key_rd, key_wr, relock_wr;

  assign n_strb    = 3'(rd8) + 3'(rd16) + 3'(wr8) + 3'(wr16);
  assign any_acc   = (n_strb != 3'd0);
  assign one_acc   = (n_strb == 3'd1);
  assign key_rd    = one_acc && rd16 && (addr == ADDR_W'(OFF_KEY_RD));
  assign key_wr    = one_acc && wr8 && (addr == ADDR_W'(OFF_LOCK)) &&
                     (wbyte == BYTE_W'(KEY_UNLOCK));
  assign relock_wr = one_acc && wr8 && (addr == ADDR_W'(OFF_LOCK)) &&
                     (wbyte == BYTE_W'(KEY_RELOCK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= 1'b0;
      st_q     <= SEQ_IDLE;
    end else if (cfg_mode) begin
      st_q <= SEQ_IDLE;
      if (relock_wr) cfg_mode <= 1'b0;
    end else if (any_acc) begin
      unique case (st_q)
        SEQ_IDLE: st_q <= key_rd ? SEQ_ONE : SEQ_IDLE;
        SEQ_ONE:  st_q <= key_rd ? SEQ_TWO : SEQ_IDLE;
        SEQ_TWO: begin
          st_q <= SEQ_IDLE;
          if (key_wr) cfg_mode <= 1'b1;
        end
        default:  st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_win_cfg.sv
module ata_win_cfg
  import ata_win_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int BYTE_W     = 8,
  parameter int NUM_DRIVES = 2,
  parameter int SETUP_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BYTE_W-1:0]            wbyte,
  input  logic                         strap,
  output logic [BYTE_W-1:0]            rbyte,
  output logic [NUM_DRIVES*BYTE_W-1:0] rd_tim_o,
  output logic [NUM_DRIVES*BYTE_W-1:0] wr_tim_o,
  output logic [SETUP_W-1:0]           setup_o,
  output logic                         live_o
);
  localparam int SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;

  logic [BYTE_W-1:0] misc_q, ctrl_q;
  logic [SEL_W-1:0]  sel;
  logic [BYTE_W-1:0] stg_rd [NUM_DRIVES];
  logic [BYTE_W-1:0] stg_wr [NUM_DRIVES];
  logic              commit;

  assign sel    = misc_q[SEL_W-1:0];
  assign commit = wr_en && (addr == ADDR_W'(OFF_CTRL)) &&
                  (wbyte == BYTE_W'(KEY_COMMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc_q  <= '0;
      ctrl_q  <= '0;
      setup_o <= '0;
      live_o  <= 1'b0;
    end else begin
      if (wr_en && addr == ADDR_W'(OFF_MISC)) misc_q <= wbyte;
      if (wr_en && addr == ADDR_W'(OFF_CTRL)) ctrl_q <= wbyte;
      if (commit) begin
        setup_o <= misc_q[BYTE_W-1 -: SETUP_W];
        live_o  <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
    logic hit;
    assign hit = wr_en && (sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_rd[g]                    <= '0;
        stg_wr[g]                    <= '0;
        rd_tim_o[g*BYTE_W +: BYTE_W] <= '0;
        wr_tim_o[g*BYTE_W +: BYTE_W] <= '0;
      end else begin
        if (hit && addr == ADDR_W'(OFF_RTIM)) stg_rd[g] <= wbyte;
        if (hit && addr == ADDR_W'(OFF_WTIM)) stg_wr[g] <= wbyte;
        if (commit) begin
          rd_tim_o[g*BYTE_W +: BYTE_W] <= stg_rd[g];
          wr_tim_o[g*BYTE_W +: BYTE_W] <= stg_wr[g];
        end
      end
    end
  end

  always_comb begin
    rbyte = '0;
    if (addr == ADDR_W'(OFF_RTIM))       rbyte = stg_rd[sel];
    else if (addr == ADDR_W'(OFF_WTIM))  rbyte = stg_wr[sel];
    else if (addr == ADDR_W'(OFF_CTRL))  rbyte = ctrl_q;
    else if (addr == ADDR_W'(OFF_STRAP)) rbyte = BYTE_W'(strap);
    else if (addr == ADDR_W'(OFF_MISC))  rbyte = misc_q;
  end
endmodule

// File: rtl/ata_win_route.sv
module ata_win_route #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              cfg_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd8,
  input  logic              rd16,
  input  logic              wr8,
  input  logic              wr16,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BYTE_W-1:0] cfg_rbyte,
  input  logic [DATA_W-1:0] tf_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cfg_wr_en,
  output logic [ADDR_W-1:0] tf_addr,
  output logic              tf_rd8,
  output logic              tf_rd16,
  output logic              tf_wr8,
  output logic              tf_wr16,
  output logic [DATA_W-1:0] tf_wdata
);
  logic single;
  assign single = (3'(rd8) + 3'(rd16) + 3'(wr8) + 3'(wr16)) == 3'd1;

  assign tf_addr  = addr;
  assign tf_wdata = wdata;
  assign tf_rd8   = rd8  && !cfg_mode;
  assign tf_rd16  = rd16 && !cfg_mode;
  assign tf_wr8   = wr8  && !cfg_mode;
  assign tf_wr16  = wr16 && !cfg_mode;

  assign cfg_wr_en = cfg_mode && single && (wr8 || wr16);
  assign rdata     = cfg_mode ? DATA_W'(cfg_rbyte) : tf_rdata;
endmodule

// File: rtl/ata_win_unlock.sv
module ata_win_unlock #(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int NUM_DRIVES = 2,
  parameter int SETUP_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            io_addr,
  input  logic                         io_rd8,
  input  logic                         io_rd16,
  input  logic                         io_wr8,
  input  logic                         io_wr16,
  input  logic [DATA_W-1:0]            io_wdata,
  output logic [DATA_W-1:0]            io_rdata,
  output logic                         cfg_mode,
  output logic [ADDR_W-1:0]            tf_addr,
  output logic                         tf_rd8,
  output logic                         tf_rd16,
  output logic                         tf_wr8,
  output logic                         tf_wr16,
  output logic [DATA_W-1:0]            tf_wdata,
  input  logic [DATA_W-1:0]            tf_rdata,
  input  logic                         clk25_strap,
  output logic [NUM_DRIVES*BYTE_W-1:0] drv_rd_tim,
  output logic [NUM_DRIVES*BYTE_W-1:0] drv_wr_tim,
  output logic [SETUP_W-1:0]           addr_setup,
  output logic                         timing_live
);
  logic [BYTE_W-1:0] cfg_rbyte;
  logic              cfg_wr_en;

  ata_win_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .addr(io_addr),
    .rd8(io_rd8), .rd16(io_rd16), .wr8(io_wr8), .wr16(io_wr16),
    .wbyte(io_wdata[BYTE_W-1:0]), .cfg_mode(cfg_mode)
  );

  ata_win_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_route (
    .cfg_mode(cfg_mode), .addr(io_addr),
    .rd8(io_rd8), .rd16(io_rd16), .wr8(io_wr8), .wr16(io_wr16),
    .wdata(io_wdata), .cfg_rbyte(cfg_rbyte), .tf_rdata(tf_rdata),
    .rdata(io_rdata), .cfg_wr_en(cfg_wr_en), .tf_addr(tf_addr),
    .tf_rd8(tf_rd8), .tf_rd16(tf_rd16), .tf_wr8(tf_wr8), .tf_wr16(tf_wr16),
    .tf_wdata(tf_wdata)
  );

  ata_win_cfg #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_DRIVES(NUM_DRIVES), .SETUP_W(SETUP_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(io_addr),
    .wbyte(io_wdata[BYTE_W-1:0]), .strap(clk25_strap), .rbyte(cfg_rbyte),
    .rd_tim_o(drv_rd_tim), .wr_tim_o(drv_wr_tim), .setup_o(addr_setup),
    .live_o(timing_live)
  );
endmodule

// File: rtl/ata_win_chk.sv
module ata_win_chk #(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int NUM_DRIVES = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [ADDR_W-1:0]            io_addr,
  input logic                         io_rd8,
  input logic                         io_rd16,
  input logic                         io_wr8,
  input logic                         io_wr16,
  input logic [DATA_W-1:0]            io_wdata,
  input logic [DATA_W-1:0]            io_rdata,
  input logic                         cfg_mode,
  input logic                         tf_rd8,
  input logic                         tf_rd16,
  input logic                         tf_wr8,
  input logic                         tf_wr16,
  input logic                         clk25_strap,
  input logic [NUM_DRIVES*BYTE_W-1:0] drv_rd_tim,
  input logic [NUM_DRIVES*BYTE_W-1:0] drv_wr_tim
);
  logic commit_req;
  assign commit_req = cfg_mode && (io_wr8 || io_wr16) && (io_addr == ADDR_W'(3)) &&
                      (io_wdata[7:0] == 8'h85);

  AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> $past(io_wr8 && io_addr == ADDR_W'(2) && io_wdata[7:0] == 8'h03)); // R3

  AST_NO_TF_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> !(tf_rd8 || tf_rd16 || tf_wr8 || tf_wr16)); // R5

  AST_RELOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_mode) |-> $past(io_wr8 && io_addr == ADDR_W'(2) && io_wdata[7:0] == 8'h83)); // R6

  AST_STRAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && io_rd8 && io_addr == ADDR_W'(5)) |-> io_rdata == DATA_W'(clk25_strap)); // R10

  AST_TIMING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_req |=> ($stable(drv_rd_tim) && $stable(drv_wr_tim))); // R9
endmodule

bind ata_win_unlock ata_win_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .NUM_DRIVES(NUM_DRIVES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd8(io_rd8), .io_rd16(io_rd16),
  .io_wr8(io_wr8), .io_wr16(io_wr16), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .cfg_mode(cfg_mode), .tf_rd8(tf_rd8), .tf_rd16(tf_rd16), .tf_wr8(tf_wr8),
  .tf_wr16(tf_wr16), .clk25_strap(clk25_strap), .drv_rd_tim(drv_rd_tim),
  .drv_wr_tim(drv_wr_tim)
);

// File: tb/ata_win_unlock_test.sv
module ata_win_unlock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  io_addr = '0;
  logic        io_rd8 = 0, io_rd16 = 0, io_wr8 = 0, io_wr16 = 0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        cfg_mode;
  logic [2:0]  tf_addr;
  logic        tf_rd8, tf_rd16, tf_wr8, tf_wr16;
  logic [15:0] tf_wdata, tf_rdata;
  logic        clk25_strap = 1'b0;
  logic [15:0] drv_rd_tim, drv_wr_tim;
  logic [3:0]  addr_setup;
  logic        timing_live;

  int n_checks = 0, n_errs = 0;
  logic [15:0] cap_rdata, cap_tfw;
  logic [3:0]  cap_tf;
  logic [2:0]  cap_tfa;

  assign tf_rdata = 16'hA500 | 16'(tf_addr);

  always #4 clk = ~clk;

  ata_win_unlock uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd8(io_rd8), .io_rd16(io_rd16),
    .io_wr8(io_wr8), .io_wr16(io_wr16), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_mode(cfg_mode), .tf_addr(tf_addr), .tf_rd8(tf_rd8), .tf_rd16(tf_rd16),
    .tf_wr8(tf_wr8), .tf_wr16(tf_wr16), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
    .clk25_strap(clk25_strap), .drv_rd_tim(drv_rd_tim), .drv_wr_tim(drv_wr_tim),
    .addr_setup(addr_setup), .timing_live(timing_live)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 rd8, 1 rd16, 2 wr8, 3 wr16
  task automatic acc(input int kind, input int addr, input logic [15:0] data);
    @(negedge clk);
    io_addr = 3'(addr); io_wdata = data;
    io_rd8 = (kind == 0); io_rd16 = (kind == 1);
    io_wr8 = (kind == 2); io_wr16 = (kind == 3);
    #2;
    cap_rdata = io_rdata; cap_tf = {tf_wr16, tf_wr8, tf_rd16, tf_rd8};
    cap_tfa = tf_addr; cap_tfw = tf_wdata;
    @(posedge clk); #1;
    io_rd8 = 0; io_rd16 = 0; io_wr8 = 0; io_wr16 = 0;
  endtask

  task automatic unlock();
    acc(1, 1, 0); acc(1, 1, 0); acc(2, 2, 16'h0003);
  endtask

  function automatic logic [7:0] rt(int d, int v); return 8'(8'h21 + d * 8'h40 + v * 8'h13); endfunction
  function automatic logic [7:0] wt(int d, int v); return 8'(8'h9C - d * 8'h30 + v * 8'h07); endfunction

  initial begin
    #200000;
    n_checks++; n_errs++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 mode", 32'(cfg_mode), 0);
    chk("R1 rd_tim", 32'(drv_rd_tim), 0);
    chk("R1 wr_tim", 32'(drv_wr_tim), 0);
    chk("R1 setup", 32'(addr_setup), 0);
    chk("R1 live", 32'(timing_live), 0);

    // R2 locked pass-through, all kinds and offsets
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 8; a++) begin
        acc(k, a, 16'h5A00 | 16'(a * 16 + k));
        chk("R2 strobes", 32'(cap_tf), 32'(4'b0001 << k));
        chk("R2 addr", 32'(cap_tfa), 32'(a));
        chk("R2 wdata", 32'(cap_tfw), 32'(16'h5A00 | 16'(a * 16 + k)));
        if (k < 2) chk("R2 rdata", 32'(cap_rdata), 32'(16'hA500 | 16'(a)));
        chk("R2 mode", 32'(cfg_mode), 0);
      end

    // R4 breaking accesses at both positions
    for (int pos = 0; pos < 2; pos++)
      for (int b = 0; b < 6; b++) begin
        int bk, ba; logic [15:0] bd;
        case (b)
          0: begin bk = 0; ba = 1; bd = 16'h0003; end
          1: begin bk = 1; ba = 0; bd = 16'h0003; end
          2: begin bk = 2; ba = 2; bd = 16'h0004; end
          3: begin bk = 3; ba = 2; bd = 16'h0003; end
          4: begin bk = 0; ba = 2; bd = 16'h0003; end
          default: begin bk = 2; ba = 3; bd = 16'h0003; end
        endcase
        acc(1, 1, 0);
        if (pos == 1) acc(1, 1, 0);
        acc(bk, ba, bd);
        if (pos == 0) acc(1, 1, 0);
        acc(2, 2, 16'h0003);
        chk("R4 stays locked", 32'(cfg_mode), 0);
        chk("R4 write passed", 32'(cap_tf), 32'(4'b0100));
      end

    // R3 correct unlock
    unlock();
    chk("R3 key write passed", 32'(cap_tf), 32'(4'b0100));
    chk("R3 unlocked", 32'(cfg_mode), 1);

    // R5/R11/R12 unlocked read sweep, strap 0
    for (int k = 0; k < 2; k++)
      for (int a = 0; a < 8; a++) begin
        acc(k, a, 0);
        chk("R5 no tf", 32'(cap_tf), 0);
        if (a == 2 || a == 4 || a == 7) chk("R11 zero read", 32'(cap_rdata), 0);
        if (a == 5) chk("R10 strap0", 32'(cap_rdata), 0);
        chk("R12 upper zero", 32'(cap_rdata[15:8]), 0);
      end

    // R7/R8 program both drives with several values, readback
    for (int v = 0; v < 4; v++) begin
      for (int d = 0; d < 2; d++) begin
        acc(2, 6, 16'(((v + 1) << 4) | d));
        acc(2, 0, 16'(rt(d, v)));
        acc(3, 1, 16'hFF00 | 16'(wt(d, v)));  // R12 wide write low byte
        chk("R5 no tf on write", 32'(cap_tf), 0);
      end
      for (int d = 0; d < 2; d++) begin
        acc(2, 6, 16'(((v + 1) << 4) | d));
        acc(0, 6, 0);
        chk("R8 misc readback", 32'(cap_rdata), 32'(((v + 1) << 4) | d));
        acc(0, 0, 0);
        chk("R7 rd timing readback", 32'(cap_rdata), 32'(rt(d, v)));
        acc(1, 1, 0);
        chk("R7 wr timing readback", 32'(cap_rdata), 32'(wt(d, v)));
      end
    end

    // R9 non-commit value
    acc(2, 3, 16'h0084);
    acc(0, 3, 0);
    chk("R9 ctrl readback", 32'(cap_rdata), 32'h84);
    chk("R9 no apply rd", 32'(drv_rd_tim), 0);
    chk("R9 no apply live", 32'(timing_live), 0);
    // commit: misc last written as setup 4, drive 1
    acc(2, 3, 16'h0085);
    chk("R9 rd applied", 32'(drv_rd_tim), 32'({rt(1, 3), rt(0, 3)}));
    chk("R9 wr applied", 32'(drv_wr_tim), 32'({wt(1, 3), wt(0, 3)}));
    chk("R9 setup applied", 32'(addr_setup), 4);
    chk("R9 live", 32'(timing_live), 1);

    // R11 writes to 2/4/7 ignored; R10 strap write ignored
    acc(2, 2, 16'h0055); chk("R11 off2 write keeps unlocked", 32'(cfg_mode), 1);
    acc(0, 2, 0); chk("R11 off2 read", 32'(cap_rdata), 0);
    acc(2, 4, 16'h00FF); acc(0, 4, 0); chk("R11 off4", 32'(cap_rdata), 0);
    acc(2, 7, 16'h00FF); acc(0, 7, 0); chk("R11 off7", 32'(cap_rdata), 0);
    acc(0, 0, 0); chk("R11 timing untouched", 32'(cap_rdata), 32'(rt(1, 3)));
    acc(2, 5, 16'h00FE); acc(0, 5, 0); chk("R10 strap write ignored", 32'(cap_rdata), 0);
    clk25_strap = 1'b1;
    acc(0, 5, 0); chk("R10 strap1", 32'(cap_rdata), 1);

    // R6 relock
    acc(2, 2, 16'h0083);
    chk("R6 relocked", 32'(cfg_mode), 0);
    acc(0, 0, 0);
    chk("R6 passthrough strobe", 32'(cap_tf), 1);
    chk("R6 passthrough data", 32'(cap_rdata), 32'hA500);
    chk("R6 outputs kept", 32'(drv_rd_tim), 32'({rt(1, 3), rt(0, 3)}));

    // R1 reset again clears applied timings
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    chk("R1 reset clears rd", 32'(drv_rd_tim), 0);
    chk("R1 reset clears live", 32'(timing_live), 0);
    unlock();
    acc(0, 6, 0); chk("R1 misc cleared", 32'(cap_rdata), 0);

    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule